// File: doc/BRIEF.md
# Two-Byte Accumulator Processor Core

This block is a compact processor built around a single 8-bit accumulator. It reads its program from a byte-wide memory space over a 13-bit address bus. Every instruction is two bytes long. The first byte carries a 3-bit operation code in its upper bits and the five upper bits of an operand address below that. The second byte carries the eight lower address bits. The core combines the accumulator with memory bytes (add, and, exclusive-or). It can load the accumulator from memory, store it to memory, skip the next instruction when the accumulator is zero, jump anywhere, and halt.

Each instruction runs through a fixed five-cycle sequence:

1. Fetch the upper instruction byte.
2. Fetch the lower instruction byte.
3. Decode.
4. Access the operand in memory.
5. Advance the program counter.

The memory interface is a plain strobe bus, because the memories answer within the cycle and never stall the core. `bus_rd` asks for a byte, which must be present on `bus_data` by the next rising edge. `bus_wr` marks a cycle in which the core drives `bus_data` and the memory captures it at the next rising edge. There is no back-pressure. The opcode, operand address and program counter are brought out so that a system can watch execution.

Top module: `acc_cpu_core`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `pc_now`, `op_now` and `opnd_addr` read 0, `halted` is 0 and the core is in its first fetch cycle (`fetch`=1, `bus_rd`=1, `bus_addr`=0). The accumulator also starts at 0.
- R2: Each instruction occupies five cycles. In cycle 1 `bus_addr`=PC, and in cycle 2 `bus_addr`=PC+1. In both of these cycles `fetch` and `bus_rd` are high. `fetch` is low in every other cycle.
- R3: Operation codes are 000 halt, 001 skip-if-zero, 010 add, 011 and, 100 xor, 101 load, 110 store, 111 jump. They sit in bits 7:5 of the first byte. The operand address is {first byte bits 4:0, second byte}. Both fields appear on `op_now` and `opnd_addr` from cycle 2 and cycle 3 onward, respectively.
- R4: In cycle 4, add, and, and xor read the byte at the operand address (`bus_rd`=1, `bus_addr`=operand). They replace the accumulator with the sum modulo 256, the AND, or the XOR. No carry is kept.
- R5: Load reads the operand byte in cycle 4 and places it in the accumulator unchanged.
- R6: Store raises `bus_wr` in cycle 4 with `bus_addr`=operand and `bus_data`=accumulator. The core leaves `bus_data` high-impedance in every cycle without `bus_wr`.
- R7: Skip-if-zero advances the PC by 4 when the accumulator is zero and by 2 otherwise. It makes no memory access.
- R8: Jump loads the operand address into the PC in cycle 5. It makes no memory access.
- R9: All other instructions add 2 to the PC in cycle 5, wrapping modulo 8192. The PC changes in no other cycle.
- R10: Halt spends cycles 1 to 3 like any instruction. From the following cycle, `halted` is 1 and stays 1 until reset, with no strobes and the PC frozen at the halt instruction.
- R11: `bus_rd` and `bus_wr` are never high together. `bus_rd` is high only in fetch cycles and in operand reads.
- R12: Pulling `rst_n` low between clock edges returns `pc_now` to 0 and `halted` to 0 at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | output | 13 | Memory byte address |
| bus_data | inout | 8 | Memory data; driven by the core only while `bus_wr` is high |
| bus_rd | output | 1 | Read strobe; data must be valid by the next rising edge |
| bus_wr | output | 1 | Write strobe; memory captures `bus_data` at the next rising edge |
| fetch | output | 1 | High during the two instruction-byte fetch cycles |
| halted | output | 1 | High after a halt instruction until reset |
| op_now | output | 3 | Operation code of the current instruction |
| opnd_addr | output | 13 | Operand address of the current instruction |
| pc_now | output | 13 | Program counter |

## Verification
A corrupted program counter or phase shows at the ports right away. `pc_now` changes, and within one cycle `bus_addr` and the strobes leave the expected five-cycle pattern. A wrong instruction register shows on `op_now` and `opnd_addr` in the same cycle. A corrupted accumulator is invisible until a later store puts it on `bus_data`, or a skip-if-zero moves the PC the wrong way. That can be several instructions later. For that reason the program stores intermediate results and the bench reads them back through later loads and a flag-controlled second pass.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;
  localparam int OPC_W = 3;

  typedef enum logic [OPC_W-1:0] {
    OP_HLT = 3'd0,
    OP_SKZ = 3'd1,
    OP_ADD = 3'd2,
    OP_AND = 3'd3,
    OP_XOR = 3'd4,
    OP_LDA = 3'd5,
    OP_STO = 3'd6,
    OP_JMP = 3'd7
  } opcode_e;

  typedef enum logic [2:0] {
    PH_FHI  = 3'd0,
    PH_FLO  = 3'd1,
    PH_DEC  = 3'd2,
    PH_EXE  = 3'd3,
    PH_ADV  = 3'd4,
    PH_STOP = 3'd5
  } phase_e;
endpackage

// File: rtl/acc_cpu_seq.sv
module acc_cpu_seq
  import acc_cpu_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  opcode_e op,
  output phase_e  phase,
  output logic    fetch,
  output logic    rd,
  output logic    wr,
  output logic    ld_hi,
  output logic    ld_lo,
  output logic    ld_acc,
  output logic    pc_en,
  output logic    halted
);
  phase_e phase_nxt;
  logic   reads_opnd;

  assign reads_opnd = (op == OP_ADD) || (op == OP_AND) ||
                      (op == OP_XOR) || (op == OP_LDA);

  always_comb begin
    case (phase)
      PH_FHI:  phase_nxt = PH_FLO;
      PH_FLO:  phase_nxt = PH_DEC;
      PH_DEC:  phase_nxt = (op == OP_HLT) ? PH_STOP : PH_EXE;
      PH_EXE:  phase_nxt = PH_ADV;
      PH_ADV:  phase_nxt = PH_FHI;
      PH_STOP: phase_nxt = PH_STOP;
      default: phase_nxt = PH_FHI;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_FHI;
    else        phase <= phase_nxt;
  end

  assign fetch  = (phase == PH_FHI) || (phase == PH_FLO);
  assign ld_hi  = (phase == PH_FHI);
  assign ld_lo  = (phase == PH_FLO);
  assign ld_acc = (phase == PH_EXE) && reads_opnd;
  assign rd     = fetch || ld_acc;
  assign wr     = (phase == PH_EXE) && (op == OP_STO);
  assign pc_en  = (phase == PH_ADV);
  assign halted = (phase == PH_STOP);

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted); // R10
  AST_HALT_AFTER_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halted) |-> ($past(phase) == PH_DEC && $past(op) == OP_HLT)); // R10
  AST_FETCH_READS: assert property (@(posedge clk) disable iff (!rst_n)
    fetch |-> (rd && !wr)); // R2
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd && wr)); // R11
endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  opcode_e           op,
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] mem_byte,
  output logic [DATA_W-1:0] res
);
  always_comb begin
    case (op)
      OP_ADD:  res = acc + mem_byte;
      OP_AND:  res = acc & mem_byte;
      OP_XOR:  res = acc ^ mem_byte;
      OP_LDA:  res = mem_byte;
      default: res = acc;
    endcase
  end
endmodule

// File: rtl/acc_cpu_dp.sv
module acc_cpu_dp
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2 * DATA_W - OPC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_hi,
  input  logic              ld_lo,
  input  logic              ld_acc,
  input  logic              pc_en,
  input  logic [DATA_W-1:0] din,
  input  logic [DATA_W-1:0] alu_res,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] opnd,
  output opcode_e           op,
  output logic [DATA_W-1:0] acc
);
  localparam int HI_A = ADDR_W - DATA_W;
  localparam logic [ADDR_W-1:0] STEP1 = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] STEP2 = ADDR_W'(4);

  logic [DATA_W-1:0] ir_hi, ir_lo;
  logic [ADDR_W-1:0] pc_nxt;

  assign op   = opcode_e'(ir_hi[DATA_W-1 -: OPC_W]);
  assign opnd = {ir_hi[HI_A-1:0], ir_lo};

  always_comb begin
    if (op == OP_JMP)                      pc_nxt = opnd;
    else if (op == OP_SKZ && acc == '0)    pc_nxt = pc + STEP2;
    else                                   pc_nxt = pc + STEP1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ir_hi <= '0;
      ir_lo <= '0;
      acc   <= '0;
      pc    <= '0;
    end else begin
      if (ld_hi)  ir_hi <= din;
      if (ld_lo)  ir_lo <= din;
      if (ld_acc) acc   <= alu_res;
      if (pc_en)  pc    <= pc_nxt;
    end
  end

  AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(pc_en) |-> $stable(pc)); // R9
  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ld_acc) |-> $stable(acc)); // R4
  AST_IR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ld_hi) |-> $stable(ir_hi)); // R3
endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W - OPC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] bus_addr,
  inout  wire  [DATA_W-1:0] bus_data,
  output logic              bus_rd,
  output logic              bus_wr,
  output logic              fetch,
  output logic              halted,
  output logic [OPC_W-1:0]  op_now,
  output logic [ADDR_W-1:0] opnd_addr,
  output logic [ADDR_W-1:0] pc_now
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  phase_e            phase;
  opcode_e           op;
  logic              ld_hi, ld_lo, ld_acc, pc_en;
  logic [ADDR_W-1:0] pc, opnd;
  logic [DATA_W-1:0] acc, alu_res, din;

  assign din      = bus_data;
  assign bus_data = bus_wr ? acc : {DATA_W{1'bz}};

  acc_cpu_seq u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .op     (op),
    .phase  (phase),
    .fetch  (fetch),
    .rd     (bus_rd),
    .wr     (bus_wr),
    .ld_hi  (ld_hi),
    .ld_lo  (ld_lo),
    .ld_acc (ld_acc),
    .pc_en  (pc_en),
    .halted (halted)
  );

  acc_cpu_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_hi   (ld_hi),
    .ld_lo   (ld_lo),
    .ld_acc  (ld_acc),
    .pc_en   (pc_en),
    .din     (din),
    .alu_res (alu_res),
    .pc      (pc),
    .opnd    (opnd),
    .op      (op),
    .acc     (acc)
  );

  acc_cpu_alu #(.DATA_W(DATA_W)) u_alu (
    .op       (op),
    .acc      (acc),
    .mem_byte (din),
    .res      (alu_res)
  );

  always_comb begin
    case (phase)
      PH_FHI:  bus_addr = pc;
      PH_FLO:  bus_addr = pc + ONE;
      PH_DEC,
      PH_EXE:  bus_addr = opnd;
      default: bus_addr = pc;
    endcase
  end

  assign op_now    = op;
  assign opnd_addr = opnd;
  assign pc_now    = pc;

  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!bus_rd && !bus_wr && !fetch)); // R10
  AST_WR_IS_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |-> (op_now == OP_STO && bus_addr == opnd_addr)); // R6
  AST_FETCH_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch && !$past(fetch)) |-> (bus_addr == pc_now)); // R2
endmodule

// File: tb/tb_acc_cpu_core.sv
module tb_acc_cpu_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  wire  [7:0]  bus;
  logic [12:0] bus_addr, opnd_addr, pc_now;
  logic        bus_rd, bus_wr, fetch, halted;
  logic [2:0]  op_now;
  logic [7:0]  tb_val = 8'h00;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  logic [7:0] mem [int];

  int m_pc, m_acc, m_ir, m_ph;
  bit m_halt;

  always #10 clk = ~clk;

  assign bus = bus_rd ? tb_val : 8'bzzzzzzzz;

  acc_cpu_core dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_data  (bus),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .fetch     (fetch),
    .halted    (halted),
    .op_now    (op_now),
    .opnd_addr (opnd_addr),
    .pc_now    (pc_now)
  );

  function automatic int rdmem(int a);
    if (mem.exists(a)) return int'(mem[a]);
    return 0;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic put(int a, int op, int opnd);
    mem[a]     = {op[2:0], opnd[12:8]};
    mem[a + 1] = opnd[7:0];
  endtask

  task automatic model_reset();
    m_pc = 0; m_acc = 0; m_ir = 0; m_ph = 0; m_halt = 1'b0;
  endtask

  // Reference model: compare this cycle's outputs, then step to the state after the next edge.
  always @(negedge clk) begin
    int op, opnd, e_addr, e_rd, e_wr, e_fetch, rv;
    if (!done) begin
      if (!rst_n) model_reset();
      op   = (m_ir >> 13) & 7;
      opnd = m_ir & 13'h1fff;
      e_rd = 0; e_wr = 0; e_fetch = 0; e_addr = m_pc;
      if (!m_halt) begin
        case (m_ph)
          0: begin e_addr = m_pc; e_rd = 1; e_fetch = 1; end
          1: begin e_addr = (m_pc + 1) & 13'h1fff; e_rd = 1; e_fetch = 1; end
          2: e_addr = opnd;
          3: begin
               e_addr = opnd;
               e_rd = (op >= 2 && op <= 5) ? 1 : 0;
               e_wr = (op == 6) ? 1 : 0;
             end
          default: e_addr = m_pc;
        endcase
      end
      chk("R1/R9", "pc_now", int'(pc_now), m_pc);
      chk("R3", "op_now", int'(op_now), op);
      chk("R3", "opnd_addr", int'(opnd_addr), opnd);
      chk("R2", "bus_addr", int'(bus_addr), e_addr);
      chk("R11", "bus_rd", int'(bus_rd), e_rd);
      chk("R6", "bus_wr", int'(bus_wr), e_wr);
      chk("R2", "fetch", int'(fetch), e_fetch);
      chk("R10", "halted", int'(halted), int'(m_halt));
      if (e_wr == 1) chk("R6", "store data", int'(bus), m_acc);
      if (!bus_rd && !bus_wr) chk("R6", "bus released", int'(bus === 8'bzzzzzzzz), 1);
      if (bus_wr) mem[int'(bus_addr)] = bus;
      tb_val = rdmem(int'(bus_addr));
      rv = rdmem(e_addr);
      if (rst_n && !m_halt) begin
        case (m_ph)
          0: begin m_ir = (rv << 8) | (m_ir & 8'hff); m_ph = 1; end
          1: begin m_ir = (m_ir & 16'hff00) | rv; m_ph = 2; end
          2: if (op == 0) m_halt = 1'b1; else m_ph = 3;
          3: begin
               case (op)
                 2: m_acc = (m_acc + rv) % 256;
                 3: m_acc = m_acc & rv;
                 4: m_acc = m_acc ^ rv;
                 5: m_acc = rv;
                 default: ;
               endcase
               m_ph = 4;
             end
          default: begin
               if (op == 7) m_pc = opnd;
               else if (op == 1 && m_acc == 0) m_pc = (m_pc + 4) % 8192;
               else m_pc = (m_pc + 2) % 8192;
               m_ph = 0;
             end
        endcase
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 3000 && !done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    model_reset();
    // data and flag
    mem[13'h1801] = 8'hff;
    mem[13'h1802] = 8'h03;
    mem[13'h1803] = 8'h0e;
    mem[13'h1804] = 8'h55;
    // program: opcodes per R3
    put(13'h0000, 5, 13'h1810);  // load flag (0 on first pass)
    put(13'h0002, 1, 0);         // skip when zero: R7 taken
    put(13'h0004, 0, 0);         // halt on second pass
    put(13'h0006, 1, 0);         // acc still 0: skip again
    put(13'h0008, 0, 0);         // skipped
    put(13'h000a, 5, 13'h1801);  // R5 load ff
    put(13'h000c, 1, 0);         // R7 not taken
    put(13'h000e, 2, 13'h1802);  // R4 ff+03 -> 02
    put(13'h0010, 3, 13'h1803);  // R4 and 0e -> 02
    put(13'h0012, 4, 13'h1804);  // R4 xor 55 -> 57
    put(13'h0014, 6, 13'h1805);  // R6 store
    put(13'h0016, 5, 13'h1805);  // reload
    put(13'h0018, 7, 13'h1ffe);  // R8 jump near top
    put(13'h1ffe, 6, 13'h1810);  // store flag, R9 wrap to 0

    repeat (3) @(posedge clk);
    #3 rst_n = 1'b1;
    while (!halted) @(posedge clk);
    repeat (4) @(posedge clk);
    #5;
    chk("R4", "result stored at 1805", rdmem(13'h1805), 8'h57);
    chk("R6", "flag stored at 1810", rdmem(13'h1810), 8'h57);
    chk("R10", "pc frozen at halt", int'(pc_now), 13'h0004);

    rst_n = 1'b0;
    #2;
    chk("R12", "pc after async reset", int'(pc_now), 0);
    chk("R12", "halted after async reset", int'(halted), 0);
    chk("R1", "fetch in reset", int'(fetch), 1);
    repeat (2) @(posedge clk);
    #3 rst_n = 1'b1;
    repeat (7) @(posedge clk);
    #5;
    chk("R9", "pc advanced before reset", int'(pc_now), 2);
    rst_n = 1'b0;
    #2;
    chk("R12", "pc cleared mid-run", int'(pc_now), 0);
    repeat (2) @(posedge clk);
    #3 rst_n = 1'b1;
    while (!halted) @(posedge clk);
    repeat (3) @(posedge clk);
    #5;
    chk("R7", "second pass halts at 4", int'(pc_now), 13'h0004);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule